// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a virtual address into a physical address using a small, software-programmable table of segments. The top bits of the virtual address pick a segment and the remaining bits are an offset within it. Each table entry holds a base, a bound, a valid flag and three access-right bits, one each for fetch, load and store. Every request carries an access type. One cycle after the request, the unit returns either a translated address or a fault with a two-bit cause.

Software loads entries through a write port made of an enable, an index and the entry fields. It rewrites them whenever the active address space changes. Reset leaves every entry invalid, so every access faults until software programs the table.

Top module: `seg_xlate`

## Requirements
- R1: The segment index is virtual address bits [15:14] and the offset is bits [13:0] (defaults VA_W=16, SEG_W=2).
- R2: For a permitted access, `ok_o` pulses in the cycle after `req_i` and `pa_o` equals base plus offset, truncated to PA_W bits (wraps modulo 2^16).
- R3: An access to an entry whose valid flag is clear gives `fault_o` with `cause_o` = 1.
- R4: An offset greater than or equal to the entry's bound gives `fault_o` with `cause_o` = 2.
- R5: Right bit 0 allows fetch (type 0), bit 1 allows load (type 1) and bit 2 allows store (type 2). Type 3 is never allowed. A disallowed access gives `fault_o` with `cause_o` = 3.
- R6: When several faults apply, the invalid-segment cause wins over the bound cause, and the bound cause wins over the protection cause.
- R7: While reset is asserted, `ok_o` and `fault_o` are low and every entry becomes invalid.
- R8: A table write is seen by requests from the next cycle on. A request in the same cycle as the write still sees the old entry.
- R9: `ok_o` and `fault_o` are never high together. Each one is high only in the cycle after a request and lasts one cycle per request.
- R10: Rewriting an entry replaces its base, bound and rights completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Table write enable |
| cfg_idx_i | input | SEG_W | Entry to write |
| cfg_valid_i | input | 1 | Valid flag to store |
| cfg_base_i | input | PA_W | Base to store |
| cfg_bound_i | input | OFF_W+1 | Bound to store |
| cfg_perm_i | input | 3 | Rights to store: bit0 fetch, bit1 load, bit2 store |
| req_i | input | 1 | Translation request |
| req_type_i | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 reserved |
| req_va_i | input | VA_W | Virtual address |
| ok_o | output | 1 | Translation succeeded |
| pa_o | output | PA_W | Physical address, meaningful only with ok_o |
| fault_o | output | 1 | Translation faulted |
| cause_o | output | 2 | Fault cause: 1 invalid, 2 bound, 3 protection |

## Verification
Addresses are aimed at each of the four segments, so a wrong segment-field slice shows up as a wrong base or a wrong fault. Offsets at bound minus one and at bound separate an off-by-one in the comparison. Each access type is tried against entries whose rights allow some types and forbid others, and requests that break several rules at once pin down the cause priority. A write paired with a request in the same cycle, a later rewrite of an entry, and a base that wraps past the top of the address range cover the table update timing and the adder width.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SEG   = 2'd1,
    FLT_BOUND = 2'd2,
    FLT_PERM  = 2'd3
  } cause_e;

  localparam int unsigned PERM_W = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned BND_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEG_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic [BND_W-1:0]  wr_bound_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [SEG_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [PA_W-1:0]   rd_base_o,
  output logic [BND_W-1:0]  rd_bound_o,
  output logic [PERM_W-1:0] rd_perm_o
);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [NSEG-1:0]   valid_q;
  logic [PA_W-1:0]   base_q  [NSEG];
  logic [BND_W-1:0]  bound_q [NSEG];
  logic [PERM_W-1:0] perm_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (wr_idx_i == SEG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        base_q[g]  <= '0;
        bound_q[g] <= '0;
        perm_q[g]  <= '0;
      end else if (hit) begin
        valid_q[g] <= wr_valid_i;
        base_q[g]  <= wr_base_i;
        bound_q[g] <= wr_bound_i;
        perm_q[g]  <= wr_perm_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_bound_o = bound_q[rd_idx_i];
  assign rd_perm_o  = perm_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 16
) (
  input  logic              valid_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [OFF_W:0]    bound_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_e              acc_i,
  output cause_e            cause_o,
  output logic [PA_W-1:0]   pa_o
);
  logic allowed;

  always_comb begin
    unique case (acc_i)
      ACC_FETCH: allowed = perm_i[0];
      ACC_LOAD:  allowed = perm_i[1];
      ACC_STORE: allowed = perm_i[2];
      default:   allowed = 1'b0;
    endcase
  end

  // priority: invalid, then bound, then rights
  always_comb begin
    if (!valid_i)                        cause_o = FLT_SEG;
    else if ({1'b0, off_i} >= bound_i)   cause_o = FLT_BOUND;
    else if (!allowed)                   cause_o = FLT_PERM;
    else                                 cause_o = FLT_NONE;
  end

  assign pa_o = base_i + PA_W'(off_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned SEG_W = 2,
  parameter int unsigned PA_W  = 16,
  localparam int unsigned OFF_W = VA_W - SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [PA_W-1:0]   cfg_base_i,
  input  logic [OFF_W:0]    cfg_bound_i,
  input  logic [2:0]        cfg_perm_i,
  input  logic              req_i,
  input  logic [1:0]        req_type_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              ok_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              fault_o,
  output logic [1:0]        cause_o
);
  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic              e_valid;
  logic [PA_W-1:0]   e_base;
  logic [OFF_W:0]    e_bound;
  logic [PERM_W-1:0] e_perm;
  cause_e            cause_d;
  logic [PA_W-1:0]   pa_d;

  assign seg = req_va_i[VA_W-1 -: SEG_W];
  assign off = req_va_i[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(OFF_W+1)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_valid_i (cfg_valid_i),
    .wr_base_i  (cfg_base_i),
    .wr_bound_i (cfg_bound_i),
    .wr_perm_i  (cfg_perm_i),
    .rd_idx_i   (seg),
    .rd_valid_o (e_valid),
    .rd_base_o  (e_base),
    .rd_bound_o (e_bound),
    .rd_perm_o  (e_perm)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .valid_i (e_valid),
    .base_i  (e_base),
    .bound_i (e_bound),
    .perm_i  (e_perm),
    .off_i   (off),
    .acc_i   (acc_e'(req_type_i)),
    .cause_o (cause_d),
    .pa_o    (pa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o    <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= FLT_NONE;
      pa_o    <= '0;
    end else begin
      ok_o    <= req_i && (cause_d == FLT_NONE);
      fault_o <= req_i && (cause_d != FLT_NONE);
      cause_o <= req_i ? cause_d : FLT_NONE;
      if (req_i) pa_o <= pa_d;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned SEG_W = 2,
  parameter int unsigned PA_W  = 16,
  localparam int unsigned OFF_W = VA_W - SEG_W,
  localparam int unsigned NSEG  = 1 << SEG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [SEG_W-1:0]  cfg_idx_i,
  input logic              cfg_valid_i,
  input logic [PA_W-1:0]   cfg_base_i,
  input logic [OFF_W:0]    cfg_bound_i,
  input logic [2:0]        cfg_perm_i,
  input logic              req_i,
  input logic [1:0]        req_type_i,
  input logic [VA_W-1:0]   req_va_i,
  input logic              ok_o,
  input logic [PA_W-1:0]   pa_o,
  input logic              fault_o,
  input logic [1:0]        cause_o
);
  logic [NSEG-1:0] sh_valid;
  logic [PA_W-1:0] sh_base  [NSEG];
  logic [OFF_W:0]  sh_bound [NSEG];
  logic [SEG_W-1:0] s;
  logic [OFF_W-1:0] o;

  assign s = req_va_i[VA_W-1 -: SEG_W];
  assign o = req_va_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_valid <= '0;
      for (int i = 0; i < NSEG; i++) begin
        sh_base[i]  <= '0;
        sh_bound[i] <= '0;
      end
    end else if (cfg_we_i) begin
      sh_valid[cfg_idx_i] <= cfg_valid_i;
      sh_base[cfg_idx_i]  <= cfg_base_i;
      sh_bound[cfg_idx_i] <= cfg_bound_i;
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fault_o));

  p_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ok_o && !fault_o);

  p_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !sh_valid[s] |=> fault_o && cause_o == 2'd1);

  p_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sh_valid[s] && ({1'b0, o} >= sh_bound[s]) |=> fault_o && cause_o == 2'd2);

  p_pa_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sh_valid[s] |=> !ok_o || pa_o == $past(sh_base[s] + PA_W'(o)));

  p_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cause_o != 2'd0);
endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W)) u_seg_xlate_chk (.*);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_base = '0;
  logic [14:0] cfg_bound = '0;
  logic [2:0]  cfg_perm = '0;
  logic        req = 1'b0;
  logic [1:0]  req_type = '0;
  logic [15:0] req_va = '0;
  logic        ok, fault;
  logic [15:0] pa;
  logic [1:0]  cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid),
    .cfg_base_i(cfg_base), .cfg_bound_i(cfg_bound), .cfg_perm_i(cfg_perm),
    .req_i(req), .req_type_i(req_type), .req_va_i(req_va),
    .ok_o(ok), .pa_o(pa), .fault_o(fault), .cause_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic v, input logic [15:0] b,
                    input logic [14:0] bd, input logic [2:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_base = b; cfg_bound = bd; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expect ok with pa, or a fault with cause (exp_cause 0 = ok)
  task automatic xl(input string tag, input logic [1:0] seg, input logic [13:0] off,
                    input logic [1:0] ty, input logic [1:0] exp_cause, input logic [15:0] exp_pa);
    @(negedge clk);
    req = 1'b1; req_type = ty; req_va = {seg, off};
    @(negedge clk);
    req = 1'b0;
    chk({tag, " ok"}, 32'(ok), 32'(exp_cause == 2'd0));
    chk({tag, " fault"}, 32'(fault), 32'(exp_cause != 2'd0));
    if (exp_cause == 2'd0) chk({tag, " pa"}, 32'(pa), 32'(exp_pa));
    else chk({tag, " cause"}, 32'(cause), 32'(exp_cause));
  endtask

  task automatic t_reset;
    chk("R7 ok in reset", 32'(ok), 0);
    chk("R7 fault in reset", 32'(fault), 0);
    @(negedge clk); rst_n = 1'b1;
    xl("R7 seg1 after reset", 2'd1, 14'h10, 2'd1, 2'd1, '0);
    xl("R7 seg3 after reset", 2'd3, 14'h0, 2'd0, 2'd1, '0);
  endtask

  task automatic t_load;
    wr(2'd0, 1'b1, 16'h4000, 15'h0700, 3'b011);
    wr(2'd1, 1'b1, 16'h0000, 15'h0500, 3'b111);
    wr(2'd2, 1'b0, 16'h0000, 15'h0000, 3'b000);
    wr(2'd3, 1'b1, 16'h2000, 15'h1000, 3'b110);
  endtask

  task automatic t_basic;
    xl("R2 R1 seg3 0x100", 2'd3, 14'h100, 2'd1, 2'd0, 16'h2100);
    xl("R2 R1 seg0 0xff", 2'd0, 14'h0ff, 2'd0, 2'd0, 16'h40ff);
    xl("R2 R1 seg1 store", 2'd1, 14'h4ff, 2'd2, 2'd0, 16'h04ff);
    xl("R3 seg2", 2'd2, 14'h0ff, 2'd1, 2'd1, '0);
    xl("R4 seg1 0x2000", 2'd1, 14'h2000, 2'd1, 2'd2, '0);
    // idle cycle: no pulse
    @(negedge clk);
    chk("R9 idle ok", 32'(ok), 0);
    chk("R9 idle fault", 32'(fault), 0);
  endtask

  task automatic t_bound_edge;
    xl("R4 seg0 last", 2'd0, 14'h6ff, 2'd1, 2'd0, 16'h46ff);
    xl("R4 seg0 at bound", 2'd0, 14'h700, 2'd1, 2'd2, '0);
    xl("R4 seg3 at bound", 2'd3, 14'h1000, 2'd2, 2'd2, '0);
  endtask

  task automatic t_perm;
    xl("R5 seg0 store", 2'd0, 14'h10, 2'd2, 2'd3, '0);
    xl("R5 seg3 fetch", 2'd3, 14'h10, 2'd0, 2'd3, '0);
    xl("R5 seg3 store", 2'd3, 14'h10, 2'd2, 2'd0, 16'h2010);
    xl("R5 seg1 type3", 2'd1, 14'h10, 2'd3, 2'd3, '0);
  endtask

  task automatic t_prio;
    xl("R6 bound over perm", 2'd0, 14'h700, 2'd2, 2'd2, '0);
    xl("R6 invalid over all", 2'd2, 14'h3fff, 2'd3, 2'd1, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_valid = 1'b1; cfg_base = 16'h8000;
    cfg_bound = 15'h0100; cfg_perm = 3'b111;
    req = 1'b1; req_type = 2'd1; req_va = {2'd2, 14'h20};
    @(negedge clk);
    cfg_we = 1'b0; req = 1'b0;
    chk("R8 same-cycle old entry fault", 32'(fault), 1);
    chk("R8 same-cycle cause", 32'(cause), 1);
    xl("R8 next cycle new entry", 2'd2, 14'h20, 2'd1, 2'd0, 16'h8020);
  endtask

  task automatic t_rewrite;
    wr(2'd0, 1'b1, 16'hfff0, 15'h0040, 3'b100);
    xl("R10 new base wraps R2", 2'd0, 14'h20, 2'd2, 2'd0, 16'h0010);
    xl("R10 old rights gone", 2'd0, 14'h20, 2'd1, 2'd3, '0);
    xl("R10 new bound", 2'd0, 14'h40, 2'd2, 2'd2, '0);
    wr(2'd3, 1'b0, 16'h2000, 15'h1000, 3'b111);
    xl("R10 R3 invalidated", 2'd3, 14'h100, 2'd1, 2'd1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_basic();
    t_bound_edge();
    t_perm();
    t_prio();
    t_same_cycle();
    t_rewrite();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule